// File: doc/BRIEF.md
# Dual-Clock Registered Embedded RAM

This block is a 2048-bit on-chip memory with one write port and one read port. Two clocks drive it. The input clock captures every request into a register before the request reaches the storage array: write data, write enable, read enable, write address and read address. The output clock captures the word the array returns. Each side has its own clock enable, and one asynchronous clear resets every pipeline register. The clear does not touch the stored words.

A registered write request is applied to the array by a write strobe stage on the next input-clock edge. The read path is different. The registered read address selects a word straight away, and the output register takes that word when the registered read enable and the output clock enable are both high.

The array shape is fixed at elaboration and always holds 2048 bits. A single-port variant uses the write address for both the read and the write.

Top module: `split_clock_ram`

## Requirements
- R1: A read request is registered on an input-clock edge while `in_ce` is high. The word at the registered address appears on `rd_data` after the next rising edge of `out_clk`. A read and a write to different addresses may be requested in the same cycle.
- R2: While `in_ce` is low, all input registers keep their values. A request presented on that edge is ignored: it writes nothing and reads nothing. An earlier registered read or write stays in effect.
- R3: A registered write stores `wr_data` at `wr_addr` on the next input-clock edge. A read requested in the following input cycle returns the new word.
- R4: When a read and a write to the same address are registered on the same input edge, the read returns the word stored before that write.
- R5: `rd_data` takes a new value only on an `out_clk` edge where both the registered read enable and `out_ce` are high. On every other edge it holds its value.
- R6: With `out_ce` low, `rd_data` holds even when a read is registered. The input side keeps running during that time.
- R7: While `aclr` is high, every pipeline register is reset at once, without waiting for a clock edge. `rd_data` is zero during the clear and stays zero until the first read is loaded afterwards.
- R8: The clear does not change the stored words. A word written before a clear reads back unchanged after it.
- R9: `WIDTH` must be one of 1, 2, 4, 8 or 16. The depth is 2048/`WIDTH` and the address width is log2 of the depth, so the default of 8 gives addresses 0 to 255. Any other width stops elaboration.
- R10: With `SINGLE_PORT` set, the registered write address selects the word for reads as well as writes, and `rd_addr` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_clk | input | 1 | Clock for all input-side registers and the array write |
| out_clk | input | 1 | Clock for the read data register |
| aclr | input | 1 | Asynchronous clear of all pipeline registers, active high |
| in_ce | input | 1 | Clock enable of the input registers |
| out_ce | input | 1 | Clock enable of the read data register |
| wr_en | input | 1 | Write request |
| rd_en | input | 1 | Read request |
| wr_addr | input | AW | Write address; in single-port mode also the read address |
| rd_addr | input | AW | Read address; unused in single-port mode |
| wr_data | input | WIDTH | Word to be written |
| rd_data | output | WIDTH | Registered read word |

## Verification
The bound checker watches the register-level rules on every clock edge:
- enabled requests are captured on the input side, and all input registers hold while `in_ce` is low;
- each enabled write request raises the write strobe;
- the output register loads exactly the word the array presents when a load is permitted, and holds otherwise;
- `rd_data` is zero throughout a clear.

Some behaviours only the bench scenarios can show, because they depend on the array contents over several cycles:
- read-back after writes at both ends of the address range;
- the old-data result of a same-address collision;
- a read that was held by a low `in_ce` completing later;
- stored words surviving a clear;
- `rd_addr` being ignored in single-port mode.

// File: rtl/split_ram_pkg.sv
`timescale 1ns/1ps
package split_ram_pkg;
  localparam int unsigned RAM_BITS = 2048;

  // true for the word widths that tile the fixed bit budget
  function automatic bit shape_ok(input int unsigned w);
    return (w == 1) || (w == 2) || (w == 4) || (w == 8) || (w == 16);
  endfunction

  function automatic int unsigned shape_depth(input int unsigned w);
    return RAM_BITS / w;
  endfunction

  function automatic int unsigned addr_bits(input int unsigned depth);
    return (depth < 2) ? 1 : $clog2(depth);
  endfunction
endpackage

// File: rtl/ram_in_stage.sv
`timescale 1ns/1ps
// Input-side request registers, clocked by the input clock.
module ram_in_stage #(
  parameter int unsigned W  = 8,
  parameter int unsigned AW = 8
) (
  input  logic          clk,
  input  logic          aclr,
  input  logic          ce,
  input  logic          we_d,
  input  logic          re_d,
  input  logic [AW-1:0] wa_d,
  input  logic [AW-1:0] ra_d,
  input  logic [W-1:0]  wd_d,
  output logic          we_q,
  output logic          re_q,
  output logic [AW-1:0] wa_q,
  output logic [AW-1:0] ra_q,
  output logic [W-1:0]  wd_q
);
  always_ff @(posedge clk or posedge aclr) begin
    if (aclr) begin
      we_q <= 1'b0;
      re_q <= 1'b0;
      wa_q <= '0;
      ra_q <= '0;
      wd_q <= '0;
    end else if (ce) begin
      we_q <= we_d;
      re_q <= re_d;
      wa_q <= wa_d;
      ra_q <= ra_d;
      wd_q <= wd_d;
    end
  end
endmodule

// File: rtl/ram_wr_strobe.sv
`timescale 1ns/1ps
// Turns the registered write enable into the array write strobe.
// The strobe is held off while the clear is active, so a clear can never
// coincide with a write into the array.
module ram_wr_strobe (
  input  logic aclr,
  input  logic we_q,
  output logic stb
);
  assign stb = we_q & ~aclr;
endmodule

// File: rtl/ram_array.sv
`timescale 1ns/1ps
// Storage: synchronous write on the input clock, combinational read.
// The array has no reset; only the pipeline around it is cleared.
module ram_array #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 256,
  parameter int unsigned AW    = 8
) (
  input  logic          clk,
  input  logic          stb,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd,
  input  logic [AW-1:0] ra,
  output logic [W-1:0]  rd_word
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (stb) mem[wa] <= wd;
  end

  assign rd_word = mem[ra];
endmodule

// File: rtl/ram_out_stage.sv
`timescale 1ns/1ps
// Output data register on its own clock and enable.
module ram_out_stage #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         aclr,
  input  logic         ce,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic         fire,
  output logic [W-1:0] q
);
  assign fire = ce & load;

  always_ff @(posedge clk or posedge aclr) begin
    if (aclr)      q <= '0;
    else if (fire) q <= d;
  end
endmodule

// File: rtl/split_clock_ram.sv
`timescale 1ns/1ps
// Dual-clock registered RAM: registered inputs on in_clk, registered
// read data on out_clk, fixed 2048-bit budget, selectable aspect ratio.
module split_clock_ram #(
  parameter int unsigned WIDTH       = 8,
  parameter bit          SINGLE_PORT = 1'b0,
  localparam int unsigned DEPTH      = split_ram_pkg::shape_depth(WIDTH),
  localparam int unsigned AW         = split_ram_pkg::addr_bits(DEPTH)
) (
  input  logic             in_clk,
  input  logic             out_clk,
  input  logic             aclr,
  input  logic             in_ce,
  input  logic             out_ce,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [AW-1:0]    rd_addr,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] rd_data
);
  // shape legality is settled at elaboration
  if (!split_ram_pkg::shape_ok(WIDTH)) begin : g_bad_shape
    $error("split_clock_ram: WIDTH must be 1, 2, 4, 8 or 16");
  end

  // registered requests (named so the checker can see them)
  logic             we_q;
  logic             re_q;
  logic [AW-1:0]    wa_q;
  logic [AW-1:0]    ra_q;
  logic [WIDTH-1:0] wd_q;
  logic             wr_stb;
  logic [AW-1:0]    arr_ra;
  logic [WIDTH-1:0] arr_word;
  logic             out_fire;

  ram_in_stage #(.W(WIDTH), .AW(AW)) u_in (
    .clk  (in_clk),
    .aclr (aclr),
    .ce   (in_ce),
    .we_d (wr_en),
    .re_d (rd_en),
    .wa_d (wr_addr),
    .ra_d (rd_addr),
    .wd_d (wr_data),
    .we_q (we_q),
    .re_q (re_q),
    .wa_q (wa_q),
    .ra_q (ra_q),
    .wd_q (wd_q)
  );

  ram_wr_strobe u_stb (
    .aclr (aclr),
    .we_q (we_q),
    .stb  (wr_stb)
  );

  // read address source: shared with the write address in single-port mode
  if (SINGLE_PORT) begin : g_single
    assign arr_ra = wa_q;
  end else begin : g_dual
    assign arr_ra = ra_q;
  end

  ram_array #(.W(WIDTH), .DEPTH(DEPTH), .AW(AW)) u_arr (
    .clk     (in_clk),
    .stb     (wr_stb),
    .wa      (wa_q),
    .wd      (wd_q),
    .ra      (arr_ra),
    .rd_word (arr_word)
  );

  ram_out_stage #(.W(WIDTH)) u_out (
    .clk  (out_clk),
    .aclr (aclr),
    .ce   (out_ce),
    .load (re_q),
    .d    (arr_word),
    .fire (out_fire),
    .q    (rd_data)
  );
endmodule

// File: rtl/split_ram_chk.sv
`timescale 1ns/1ps
// Cycle-level checks on the pipeline registers of split_clock_ram.
module split_ram_chk #(
  parameter int unsigned W  = 8,
  parameter int unsigned AW = 8
) (
  input logic          in_clk,
  input logic          out_clk,
  input logic          aclr,
  input logic          in_ce,
  input logic          out_ce,
  input logic          wr_en,
  input logic          rd_en,
  input logic          re_q,
  input logic          we_q,
  input logic [AW-1:0] wa_q,
  input logic [AW-1:0] ra_q,
  input logic [W-1:0]  wd_q,
  input logic          wr_stb,
  input logic [W-1:0]  arr_word,
  input logic [W-1:0]  rd_data
);
  assert_rd_capture_R1: assert property (@(posedge in_clk) disable iff (aclr)
    (in_ce && rd_en) |=> re_q);

  assert_in_hold_R2: assert property (@(posedge in_clk) disable iff (aclr)
    !in_ce |=> $stable({we_q, re_q, wa_q, ra_q, wd_q}));

  assert_wr_strobe_R3: assert property (@(posedge in_clk) disable iff (aclr)
    (in_ce && wr_en) |=> wr_stb);

  assert_out_load_R5: assert property (@(posedge out_clk) disable iff (aclr)
    (out_ce && re_q) |=> (rd_data == $past(arr_word)));

  assert_out_hold_R6: assert property (@(posedge out_clk) disable iff (aclr)
    !(out_ce && re_q) |=> $stable(rd_data));

  always @(posedge out_clk) begin
    if (aclr) begin
      assert_clear_zero_R7: assert (rd_data == '0)
        else $error("rd_data not zero during clear");
    end
  end
endmodule

bind split_clock_ram split_ram_chk #(.W(WIDTH), .AW(AW)) u_chk (
  .in_clk   (in_clk),
  .out_clk  (out_clk),
  .aclr     (aclr),
  .in_ce    (in_ce),
  .out_ce   (out_ce),
  .wr_en    (wr_en),
  .rd_en    (rd_en),
  .re_q     (re_q),
  .we_q     (we_q),
  .wa_q     (wa_q),
  .ra_q     (ra_q),
  .wd_q     (wd_q),
  .wr_stb   (wr_stb),
  .arr_word (arr_word),
  .rd_data  (rd_data)
);

// File: tb/split_clock_ram_tb.sv
`timescale 1ns/1ps
module split_clock_ram_tb;
  logic in_clk = 1'b0;
  logic out_clk = 1'b0;
  logic aclr, in_ce, out_ce, we, re;
  logic [7:0] wa, ra, wd, rd8;
  logic [8:0] sp_wa, sp_ra;
  logic [3:0] sp_wd, rd4;

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;

  // reference state derived from the requirements
  logic [7:0] m8 [256];
  logic [3:0] m4 [512];
  bit         q_we, q_re;
  logic [7:0] q_wa, q_ra, q_wd, e8;
  logic [3:0] q_wd4, e4;

  typedef struct {
    int         due;
    logic [7:0] e8;
    logic [3:0] e4;
    string      tag;
  } exp_t;
  exp_t sb[$];

  // 50 MHz input clock; output clock same rate, rising 5 ns later
  always #10 in_clk = ~in_clk;
  initial begin
    #5;
    forever #10 out_clk = ~out_clk;
  end
  always @(posedge in_clk) cyc <= cyc + 1;

  split_clock_ram #(.WIDTH(8), .SINGLE_PORT(1'b0)) u_dut (
    .in_clk(in_clk), .out_clk(out_clk), .aclr(aclr), .in_ce(in_ce), .out_ce(out_ce),
    .wr_en(we), .rd_en(re), .wr_addr(wa), .rd_addr(ra), .wr_data(wd), .rd_data(rd8)
  );

  split_clock_ram #(.WIDTH(4), .SINGLE_PORT(1'b1)) u_sp (
    .in_clk(in_clk), .out_clk(out_clk), .aclr(aclr), .in_ce(in_ce), .out_ce(out_ce),
    .wr_en(we), .rd_en(re), .wr_addr(sp_wa), .rd_addr(sp_ra), .wr_data(sp_wd), .rd_data(rd4)
  );

  function automatic logic [3:0] nib(input logic [7:0] d);
    return d[3:0] ^ d[7:4];
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // driver: one input cycle of stimulus, pushes the expected outputs
  task automatic step(input bit ice, input bit oce, input bit w, input bit r,
                      input logic [7:0] a_w, input logic [7:0] a_r,
                      input logic [7:0] d, input string tag);
    exp_t it;
    @(negedge in_clk);
    in_ce = ice; out_ce = oce; we = w; re = r;
    wa = a_w; ra = a_r; wd = d;
    sp_wa = {1'b0, a_w}; sp_ra = ~{1'b0, a_r}; sp_wd = nib(d);
    if (q_we) begin
      m8[q_wa] = q_wd;
      m4[{1'b0, q_wa}] = q_wd4;
    end
    if (ice) begin
      q_we = w; q_re = r; q_wa = a_w; q_ra = a_r; q_wd = d; q_wd4 = nib(d);
    end
    if (oce && q_re) begin
      e8 = m8[q_ra];
      e4 = m4[{1'b0, q_wa}];
    end
    it.due = cyc + 1; it.e8 = e8; it.e4 = e4; it.tag = tag;
    sb.push_back(it);
  endtask

  // monitor: compares both instances when each item falls due
  initial begin
    exp_t it;
    forever begin
      @(negedge in_clk);
      #2;
      while (sb.size() > 0 && sb[0].due <= cyc) begin
        it = sb.pop_front();
        check(it.tag, {8'h00, rd8}, {8'h00, it.e8});
        check({"R10 single-port / ", it.tag}, {12'h000, rd4}, {12'h000, it.e4});
      end
    end
  end

  task automatic do_clear();
    @(negedge in_clk);
    #3;
    aclr = 1'b1; in_ce = 1'b0; out_ce = 1'b0; we = 1'b0; re = 1'b0;
    #1;
    check("R7 rd_data zero at clear", {8'h00, rd8}, 16'h0);
    check("R7 single-port zero at clear", {12'h000, rd4}, 16'h0);
    repeat (2) @(negedge in_clk);
    check("R7 rd_data zero while clear held", {8'h00, rd8}, 16'h0);
    #3;
    aclr = 1'b0;
    q_we = 1'b0; q_re = 1'b0; q_wa = '0; q_ra = '0; q_wd = '0; q_wd4 = '0;
    e8 = '0; e4 = '0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #400000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, got hang expected completion");
    summary();
    $finish;
  end

  initial begin
    aclr = 1'b1; in_ce = 1'b0; out_ce = 1'b0; we = 1'b0; re = 1'b0;
    wa = '0; ra = '0; wd = '0; sp_wa = '0; sp_ra = '0; sp_wd = '0;
    q_we = 1'b0; q_re = 1'b0; q_wa = '0; q_ra = '0; q_wd = '0; q_wd4 = '0;
    e8 = '0; e4 = '0;
    repeat (3) @(negedge in_clk);
    check("R7 reset value", {8'h00, rd8}, 16'h0);
    check("R7 reset value single-port", {12'h000, rd4}, 16'h0);
    #3 aclr = 1'b0;

    // fill, covering address 0 and the top address 255 (R9)
    for (int i = 0; i < 16; i++)
      step(1, 1, 1, 0, 8'(i * 17), 8'h00, 8'(i * 29 + 3), "R5 hold while no read");
    for (int i = 0; i < 16; i++)
      step(1, 1, 0, 1, 8'(i * 17), 8'(i * 17), 8'h00, "R1 R9 read back");

    // write then read next cycle, then a same-address collision
    step(1, 1, 1, 0, 8'h40, 8'h00, 8'hC3, "R5 hold during write");
    step(1, 1, 0, 1, 8'h40, 8'h40, 8'h00, "R3 read after write");
    step(1, 1, 1, 1, 8'h40, 8'h40, 8'h3C, "R4 old word on collision");
    step(1, 1, 0, 1, 8'h40, 8'h40, 8'h00, "R3 new word next cycle");

    // input enable low: request ignored, held read repeats
    step(0, 1, 1, 1, 8'h22, 8'h22, 8'hEE, "R2 held read repeats");
    step(1, 1, 0, 1, 8'h22, 8'h22, 8'h00, "R2 ignored write left word intact");

    // output enable low: output holds although a read is registered
    step(1, 1, 0, 1, 8'h11, 8'h11, 8'h00, "R1 read 0x11");
    step(1, 0, 0, 1, 8'h33, 8'h33, 8'h00, "R6 out_ce low holds");
    step(0, 1, 0, 0, 8'h00, 8'h00, 8'h00, "R2 held read completes");
    step(1, 1, 0, 0, 8'h00, 8'h00, 8'h00, "R5 no read holds");

    // simultaneous write and read of different addresses
    step(1, 1, 1, 1, 8'h55, 8'h66, 8'h99, "R1 simultaneous ports");
    step(1, 1, 0, 1, 8'h55, 8'h55, 8'h00, "R3 simultaneous write landed");

    // clear: registers reset, contents kept
    step(1, 1, 0, 1, 8'h44, 8'h44, 8'h00, "R1 read before clear");
    do_clear();
    step(1, 1, 0, 0, 8'h44, 8'h44, 8'h00, "R7 zero until first read");
    step(1, 1, 0, 1, 8'h44, 8'h44, 8'h00, "R8 word kept across clear");
    step(1, 1, 0, 0, 8'h00, 8'h00, 8'h00, "R5 final hold");

    repeat (3) @(negedge in_clk);
    #4;
    summary();
    $finish;
  end
endmodule